// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is one bank of general-purpose pins (16 by default) with per-pin edge detection and a single interrupt line shared by all the pins. Software reaches it over a small memory-mapped bus with an address, a write strobe with write data, and a read strobe that returns read data in the same cycle. Every pin can be armed for rising edges, for falling edges, or for both. When an armed edge is seen, the pin's own bit in a sticky status word is set, so a handler can find out which pins fired even though they share one line.

The output data word can be written whole, or changed one bit at a time through a set alias and a clear alias. The edge-arming masks are written only through set and clear aliases. Both aliases of a pair read back the same live mask. Status bits are cleared only by software, by writing ones to them. Every armed edge raises a new one-cycle pulse on the bank interrupt line, even when that pin's status bit is still pending. This lets an interrupt controller that counts pulses see each event. A bank-level enable gates the pulse but does not gate the status bits. Pin inputs go through a two-flop synchronizer before edge detection.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset the output data, both edge masks, the status word, the bank enable and the interrupt output are all zero.
- R2: Offset 0x10 writes the output data word. Writing ones at offset 0x14 drives those pins high, and writing ones at offset 0x18 drives them low. Zero bits leave pins unchanged. All three offsets read the current output word, and that word appears on the output pins.
- R3: Offset 0x20 reads the pin levels through a two-stage synchronizer. Bit i is pin i. Writes to 0x20 have no effect.
- R4: Ones written at offset 0x24 arm rising edges and ones written at offset 0x28 disarm them. Offsets 0x2C and 0x30 do the same for falling edges. Each pair of offsets reads back the same current mask.
- R5: A 0-to-1 change on a pin armed for rising edges, or a 1-to-0 change on a pin armed for falling edges, sets that pin's bit in the status word at offset 0x34. An edge of the unarmed polarity sets nothing.
- R6: Writing ones to offset 0x34 clears those status bits. Zero bits have no effect, and the hardware never clears a status bit by itself.
- R7: For a qualifying edge, the interrupt output is high for exactly one cycle. The pulse starts on the third rising clock edge after the pin changes, in the same cycle that the status bit becomes visible.
- R8: A qualifying edge raises a new pulse even when its status bit is already set.
- R9: Edges on several pins that qualify in the same cycle give one pulse and set all of their status bits.
- R10: Bit 0 of offset 0x00 is the bank interrupt enable and reads back. While it is zero no pulse is produced, but status bits are still set.
- R11: When an edge sets a status bit in the same cycle that software clears that bit, the bit ends up set.
- R12: Reads of unmapped offsets return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the strobe, zero when the strobe is low |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output data driven to the pins |
| bank_irq | output | 1 | One-cycle bank interrupt pulse |

## Verification
A behavioural model of the bank runs beside the design and compares the output pins and the interrupt line on every clock. Directed reads are checked against both the model and fixed expected values. The stimulus covers these cases:
- a lone rising edge and a lone falling edge on armed pins, and an edge of the unarmed polarity, to separate the two masks;
- repeated toggles while a status bit is still pending, to show that a new pulse appears on every edge;
- two pins changing together, to tell one merged pulse apart from two pulses;
- an edge with the bank disabled, to show that the status bit is set while the line stays low;
- a status clear that lands in the same cycle as a new edge, to show that the set is kept.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 8;

    // Byte offsets of the register window
    localparam logic [ADDR_W-1:0] OFS_IEN      = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_OUT      = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_OUT_SET  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_OUT_CLR  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_IN       = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_RISE_SET = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_RISE_CLR = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_FALL_SET = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_FALL_CLR = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_STAT     = 8'h34;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_IEN,
        SEL_OUT,
        SEL_OUT_SET,
        SEL_OUT_CLR,
        SEL_IN,
        SEL_RISE_SET,
        SEL_RISE_CLR,
        SEL_FALL_SET,
        SEL_FALL_CLR,
        SEL_STAT
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_IEN:      return SEL_IEN;
            OFS_OUT:      return SEL_OUT;
            OFS_OUT_SET:  return SEL_OUT_SET;
            OFS_OUT_CLR:  return SEL_OUT_CLR;
            OFS_IN:       return SEL_IN;
            OFS_RISE_SET: return SEL_RISE_SET;
            OFS_RISE_CLR: return SEL_RISE_CLR;
            OFS_FALL_SET: return SEL_FALL_SET;
            OFS_FALL_CLR: return SEL_FALL_CLR;
            OFS_STAT:     return SEL_STAT;
            default:      return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q = chain_q[LAST];
endmodule

// File: rtl/gpio_bank_edge.sv
module gpio_bank_edge #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    // A pin qualifies when its level moved in an armed direction
    assign hit = (lvl & ~prev_q & rise_en) | (~lvl & prev_q & fall_en);
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int N_PINS      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [N_PINS-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic              bank_irq
);
    typedef struct packed {
        logic              ien;
        logic [N_PINS-1:0] dout;
        logic [N_PINS-1:0] rise;
        logic [N_PINS-1:0] fall;
        logic [N_PINS-1:0] stat;
        logic              irq;
    } bank_state_t;

    bank_state_t st_d, st_q;

    logic [N_PINS-1:0] lvl_sync;
    logic [N_PINS-1:0] edge_hit;
    logic [N_PINS-1:0] rise_en;
    logic [N_PINS-1:0] fall_en;
    logic [N_PINS-1:0] stat_bits;
    logic              irq_en;
    logic [N_PINS-1:0] stat_clr;
    reg_sel_e          wsel;
    reg_sel_e          rsel;

    assign rise_en   = st_q.rise;
    assign fall_en   = st_q.fall;
    assign stat_bits = st_q.stat;
    assign irq_en    = st_q.ien;

    gpio_bank_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lvl_sync)
    );

    gpio_bank_edge #(.W(N_PINS)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl_sync),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .hit     (edge_hit)
    );

    always_comb begin
        st_d     = st_q;
        wsel     = bus_wr ? decode_ofs(bus_addr) : SEL_NONE;
        stat_clr = '0;
        case (wsel)
            SEL_IEN:      st_d.ien  = bus_wdata[0];
            SEL_OUT:      st_d.dout = bus_wdata;
            SEL_OUT_SET:  st_d.dout = st_q.dout | bus_wdata;
            SEL_OUT_CLR:  st_d.dout = st_q.dout & ~bus_wdata;
            SEL_RISE_SET: st_d.rise = st_q.rise | bus_wdata;
            SEL_RISE_CLR: st_d.rise = st_q.rise & ~bus_wdata;
            SEL_FALL_SET: st_d.fall = st_q.fall | bus_wdata;
            SEL_FALL_CLR: st_d.fall = st_q.fall & ~bus_wdata;
            SEL_STAT:     stat_clr  = bus_wdata;
            default:      ;
        endcase
        // new edges are OR-ed in after the clear, so a set wins
        st_d.stat = (stat_bits & ~stat_clr) | edge_hit;
        st_d.irq  = irq_en & (|edge_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rsel      = bus_rd ? decode_ofs(bus_addr) : SEL_NONE;
        bus_rdata = '0;
        case (rsel)
            SEL_IEN:                            bus_rdata[0] = irq_en;
            SEL_OUT, SEL_OUT_SET, SEL_OUT_CLR:  bus_rdata    = st_q.dout;
            SEL_IN:                             bus_rdata    = lvl_sync;
            SEL_RISE_SET, SEL_RISE_CLR:         bus_rdata    = rise_en;
            SEL_FALL_SET, SEL_FALL_CLR:         bus_rdata    = fall_en;
            SEL_STAT:                           bus_rdata    = stat_bits;
            default:                            bus_rdata    = '0;
        endcase
    end

    assign pin_out  = st_q.dout;
    assign bank_irq = st_q.irq;
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int N_PINS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N_PINS-1:0] bus_wdata,
    input logic [N_PINS-1:0] pin_out,
    input logic              bank_irq,
    input logic              irq_en,
    input logic [N_PINS-1:0] stat_bits,
    input logic [N_PINS-1:0] rise_en
);
    logic wr_stat, wr_oset, wr_oclr, wr_rset;
    assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
    assign wr_oset = bus_wr && (bus_addr == OFS_OUT_SET);
    assign wr_oclr = bus_wr && (bus_addr == OFS_OUT_CLR);
    assign wr_rset = bus_wr && (bus_addr == OFS_RISE_SET);

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stat) |-> ((stat_bits & $past(stat_bits)) == $past(stat_bits))); // R6

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        bank_irq |-> $past(irq_en)); // R10

    AST_IRQ_MARKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        bank_irq |-> (stat_bits != '0)); // R5

    AST_OUT_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_oset) |-> ((pin_out & $past(bus_wdata)) == $past(bus_wdata))); // R2

    AST_OUT_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_oclr) |-> ((pin_out & $past(bus_wdata)) == '0)); // R2

    AST_RISE_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_rset) |-> ((rise_en & $past(bus_wdata)) == $past(bus_wdata))); // R4
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.N_PINS(N_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .bank_irq  (bank_irq),
    .irq_en    (irq_en),
    .stat_bits (stat_bits),
    .rise_en   (rise_en)
);

// File: tb/sim_gpio_edge_bank.sv
`timescale 1ns/1ps
module sim_gpio_edge_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic        bank_irq;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_edge_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .bank_irq(bank_irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_pipe [$];
    logic [15:0] m_last, m_out, m_rise, m_fall, m_stat, m_new, m_clr;
    bit          m_ien, m_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pipe = {16'h0, 16'h0};
            m_last = '0; m_out = '0; m_rise = '0; m_fall = '0; m_stat = '0;
            m_ien = 0; m_irq = 0;
        end else begin
            m_new = (m_pipe[1] & ~m_last & m_rise) | (~m_pipe[1] & m_last & m_fall);
            m_irq = m_ien && (m_new != 0);
            m_clr = '0;
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: m_ien  = bus_wdata[0];
                    8'h10: m_out  = bus_wdata;
                    8'h14: m_out  = m_out | bus_wdata;
                    8'h18: m_out  = m_out & ~bus_wdata;
                    8'h24: m_rise = m_rise | bus_wdata;
                    8'h28: m_rise = m_rise & ~bus_wdata;
                    8'h2C: m_fall = m_fall | bus_wdata;
                    8'h30: m_fall = m_fall & ~bus_wdata;
                    8'h34: m_clr  = bus_wdata;
                    default: ;
                endcase
            end
            m_stat = (m_stat & ~m_clr) | m_new;
            m_last = m_pipe[1];
            m_pipe.push_front(pin_in);
            void'(m_pipe.pop_back());
        end
    end

    function automatic logic [15:0] model_read(input logic [7:0] a);
        case (a)
            8'h00: return {15'h0, m_ien};
            8'h10, 8'h14, 8'h18: return m_out;
            8'h20: return m_pipe[1];
            8'h24, 8'h28: return m_rise;
            8'h2C, 8'h30: return m_fall;
            8'h34: return m_stat;
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 pin_out vs model", pin_out, m_out);
            check("R7 bank_irq vs model", {15'h0, bank_irq}, {15'h0, m_irq});
            if (bank_irq) pulses++;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [15:0] exp);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check({tag, " (model)"}, bus_rdata, model_read(a));
        check(tag, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    int p0;
    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd("R1 enable", 8'h00, 16'h0);
        rd("R1 output", 8'h10, 16'h0);
        rd("R1 rise mask", 8'h24, 16'h0);
        rd("R1 fall mask", 8'h2C, 16'h0);
        rd("R1 status", 8'h34, 16'h0);
        check("R1 irq", {15'h0, bank_irq}, 16'h0);

        // R2 output word and aliases
        wr(8'h10, 16'h00F0);
        wr(8'h14, 16'h0103);
        wr(8'h18, 16'h0030);
        rd("R2 out", 8'h10, 16'h01C3);
        rd("R2 out set alias", 8'h14, 16'h01C3);
        rd("R2 out clr alias", 8'h18, 16'h01C3);
        check("R2 pins", pin_out, 16'h01C3);

        // R3 synchronised input view, write ignored
        pin_in = 16'hA5A5;
        idle(3);
        rd("R3 input", 8'h20, 16'hA5A5);
        wr(8'h20, 16'h0000);
        rd("R3 input after write", 8'h20, 16'hA5A5);

        // R4 edge masks
        wr(8'h24, 16'h5011);
        wr(8'h28, 16'h0001);
        rd("R4 rise via set", 8'h24, 16'h5010);
        rd("R4 rise via clr", 8'h28, 16'h5010);
        wr(8'h2C, 16'h0300);
        rd("R4 fall via set", 8'h2C, 16'h0300);
        rd("R4 fall via clr", 8'h30, 16'h0300);

        // R10 enable reads back
        wr(8'h00, 16'h0001);
        rd("R10 enable", 8'h00, 16'h0001);

        // R5/R7 rising edge on pin 4
        p0 = pulses;
        pin_in[4] = 1'b1;
        idle(2);
        check("R7 no pulse before third edge", {15'h0, bank_irq}, 16'h0);
        idle(1);
        check("R7 pulse on third edge", {15'h0, bank_irq}, 16'h1);
        rd("R5 status rising", 8'h34, 16'h0010);
        idle(1);
        check("R7 single cycle", {15'h0, bank_irq}, 16'h0);
        check("R7 pulse count", 16'(pulses - p0), 16'd1);

        // R5 falling on pin 8, unarmed polarity on pin 9 and pin 4
        pin_in[8] = 1'b0; pin_in[9] = 1'b1; pin_in[4] = 1'b0;
        idle(4);
        rd("R5 fall sets, unarmed polarity ignored", 8'h34, 16'h0110);

        // R8 new pulse while pending
        p0 = pulses;
        pin_in[4] = 1'b1; idle(4);
        pin_in[4] = 1'b0; idle(2);
        pin_in[4] = 1'b1; idle(4);
        check("R8 pulses while pending", 16'(pulses - p0), 16'd2);

        // R6 W1C
        wr(8'h34, 16'h0000);
        rd("R6 zero write keeps", 8'h34, 16'h0110);
        wr(8'h34, 16'h0100);
        rd("R6 one clears only its bit", 8'h34, 16'h0010);
        idle(5);
        rd("R6 no auto clear", 8'h34, 16'h0010);
        wr(8'h34, 16'hFFFF);
        rd("R6 clear all", 8'h34, 16'h0000);

        // R9 two pins together
        p0 = pulses;
        pin_in[12] = 1'b1; pin_in[14] = 1'b1;
        idle(5);
        check("R9 one pulse", 16'(pulses - p0), 16'd1);
        rd("R9 both bits", 8'h34, 16'h5000);
        wr(8'h34, 16'hFFFF);

        // R10 disabled bank
        wr(8'h00, 16'h0000);
        p0 = pulses;
        pin_in[8] = 1'b1; idle(1); pin_in[8] = 1'b0;
        idle(5);
        check("R10 no pulse when disabled", 16'(pulses - p0), 16'd0);
        rd("R10 status still set", 8'h34, 16'h0100);

        // R11 set wins over simultaneous clear (pin 8 falls again)
        pin_in[8] = 1'b1; idle(4);
        pin_in[8] = 1'b0;
        idle(2);
        wr(8'h34, 16'h0100);
        rd("R11 set wins", 8'h34, 16'h0100);

        // R12 unmapped
        wr(8'h08, 16'hFFFF);
        wr(8'h3C, 16'hFFFF);
        rd("R12 unmapped 0x08", 8'h08, 16'h0000);
        rd("R12 unmapped 0x3C", 8'h3C, 16'h0000);
        rd("R12 output unchanged", 8'h10, 16'h01C3);
        rd("R12 rise unchanged", 8'h24, 16'h5010);

        idle(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule